// File: doc/BRIEF.md
# Two-Tap Video Frame Timing Generator

This block drives the timing strobes of a parallel camera-style video link: a frame-valid strobe, a line-valid strobe and a data-valid strobe. Alongside them it drives a two-tap test pattern in which every pixel clock carries two adjacent pixels. The pattern is a column counter that starts again at zero on every row and wraps at the top of the pixel word. Its purpose is to prove out a capture path before a real sensor is attached.

The frame geometry is set by parameters: pixels per line, lines per frame, blanking between lines, blanking between frames, and the number of dummy line pulses placed in the frame blanking. Values below the minimums a receiver needs are raised to those minimums. An enable input starts frames. Dropping it lets the current frame and its blanking run to the end, and the block then idles with every strobe low. A one-clock pulse marks the end of each frame. All outputs come from registers.

Top module: `vid_timing_gen`

## Requirements
- R1: On each clock of an active line, `tap_a` carries column 2k and `tap_b` carries column 2k+1, where k is the clock index within the line and columns are taken modulo 2^PIX_W. With PIX_W = 10, column 1023 is followed by 0.
- R2: The column count restarts on every line. The first data-valid clock of every line shows `tap_a` = 0 and `tap_b` = 1, and this includes the first line after enable.
- R3: `dval` is high only while both `lval` and `fval` are high. While `fval` is high, `dval` equals `lval`.
- R4: Each active line lasts PIXELS_PER_LINE/2 clocks, and each frame holds exactly LINES_PER_FRAME active lines.
- R5: Between two active lines of a frame, `lval` is low for exactly max(LINE_GAP, 4) clocks.
- R6: Between frames, `fval` is low for at least FG = max(FRAME_GAP, 100, 8*ND + 4) clocks, and for exactly FG clocks while enable stays high.
- R7: While `fval` is low between frames, exactly ND = max(DUMMY_LINES, 4) dummy `lval` pulses occur. Each is 4 clocks high, each is preceded by at least 4 low clocks, and `dval` stays low during all of them.
- R8: `fval` rises exactly one clock before the first `lval` of a frame. It falls exactly one clock after the last active `lval` falls.
- R9: In reset, and while idle, `fval`, `lval`, `dval` and `frame_done` are low. Enable sampled high while idle starts a frame. After enable is deasserted, the current frame and its blanking complete and the block then idles with all strobes low.
- R10: `frame_done` is a one-clock pulse on the first clock `fval` is low after each frame, and it occurs at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start frames; low lets the current frame finish |
| fval | output | 1 | Frame-valid strobe |
| lval | output | 1 | Line-valid strobe (active lines and dummy pulses) |
| dval | output | 1 | Data-valid strobe |
| tap_a | output | PIX_W | Even-column pixel |
| tap_b | output | PIX_W | Odd-column pixel |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench builds two instances. The first uses 1030 pixels per line, three lines, and a line gap, frame gap and dummy count all set below their minimums. With 515 pair clocks per line, the pattern crosses the 1023-to-0 wrap, and each clamp (4, 100, 4) is exercised. The second uses a 4-bit pixel word, 20 pixels per line, a line gap of 7 and 15 dummy pulses. There the rule 8*ND + 4 outweighs the requested frame gap of 120 and gives 124, and the pattern wraps at 16. Random enable windows drop enable at arbitrary points in the frame. A one-clock enable pulse checks that exactly one frame is produced.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRONT,
    ST_LINE,
    ST_LGAP,
    ST_TAIL,
    ST_FGAP
  } vtg_state_e;

  localparam int MIN_LINE_GAP  = 4;
  localparam int MIN_FRAME_GAP = 100;
  localparam int MIN_DUMMY     = 4;
  localparam int DUMMY_PERIOD  = 8;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Dummy pulses: low for 4 clocks, high for 4 clocks, nd times.
  function automatic logic dummy_on(int g, int nd);
    return ((g % DUMMY_PERIOD) >= (DUMMY_PERIOD / 2)) && ((g / DUMMY_PERIOD) < nd);
  endfunction

  function automatic int frame_gap_eff(int req, int nd);
    return max_of(max_of(req, MIN_FRAME_GAP), DUMMY_PERIOD * nd + MIN_LINE_GAP);
  endfunction

endpackage

// File: rtl/vtg_seq.sv
module vtg_seq
  import vtg_pkg::*;
#(
  parameter int PAIRS  = 320,
  parameter int LINES  = 480,
  parameter int LG     = 4,
  parameter int FG     = 100,
  parameter int ND     = 4,
  parameter int CNT_W  = 9,
  parameter int LINE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             fval_c,
  output logic             lval_c,
  output logic             dval_c,
  output logic             done_c,
  output logic [CNT_W-1:0] pair
);

  localparam logic [CNT_W-1:0]  PAIR_LAST = CNT_W'(PAIRS - 1);
  localparam logic [CNT_W-1:0]  LG_LAST   = CNT_W'(LG - 1);
  localparam logic [CNT_W-1:0]  FG_LAST   = CNT_W'(FG - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  vtg_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [LINE_W-1:0] line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      line  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (en) state <= ST_FRONT;
        ST_FRONT: begin
          state <= ST_LINE;
          cnt   <= '0;
          line  <= '0;
        end
        ST_LINE: begin
          if (cnt == PAIR_LAST) begin
            cnt   <= '0;
            state <= (line == LINE_LAST) ? ST_TAIL : ST_LGAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LGAP: begin
          if (cnt == LG_LAST) begin
            cnt   <= '0;
            line  <= line + 1'b1;
            state <= ST_LINE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          cnt   <= '0;
          state <= ST_FGAP;
        end
        ST_FGAP: begin
          if (cnt == FG_LAST) begin
            cnt   <= '0;
            state <= en ? ST_FRONT : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fval_c = (state == ST_FRONT) || (state == ST_LINE) ||
             (state == ST_LGAP)  || (state == ST_TAIL);
    dval_c = (state == ST_LINE);
    lval_c = dval_c || ((state == ST_FGAP) && dummy_on(int'(cnt), ND));
    done_c = (state == ST_FGAP) && (cnt == '0);
    pair   = cnt;
  end

  // R4: a line never runs past its last pair clock
  a_r4_line_ends: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LINE && cnt == PAIR_LAST) |=> (state != ST_LINE));

endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern #(
  parameter int CNT_W = 9,
  parameter int PIX_W = 10
) (
  input  logic [CNT_W-1:0] pair,
  output logic [PIX_W-1:0] col_even,
  output logic [PIX_W-1:0] col_odd
);

  // Column index = 2*pair + tap, truncated to the pixel word.
  function automatic logic [PIX_W-1:0] col_of(logic [CNT_W-1:0] p, logic t);
    logic [CNT_W:0] full;
    full = {p, t};
    return PIX_W'(full);
  endfunction

  assign col_even = col_of(pair, 1'b0);
  assign col_odd  = col_of(pair, 1'b1);

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int PIX_W           = 10,
  parameter int PIXELS_PER_LINE = 640,
  parameter int LINES_PER_FRAME = 480,
  parameter int LINE_GAP        = 4,
  parameter int FRAME_GAP       = 100,
  parameter int DUMMY_LINES     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             fval,
  output logic             lval,
  output logic             dval,
  output logic [PIX_W-1:0] tap_a,
  output logic [PIX_W-1:0] tap_b,
  output logic             frame_done
);

  localparam int PAIRS  = max_of(PIXELS_PER_LINE / 2, 1);
  localparam int LINES  = max_of(LINES_PER_FRAME, 1);
  localparam int LG_E   = max_of(LINE_GAP, MIN_LINE_GAP);
  localparam int ND_E   = max_of(DUMMY_LINES, MIN_DUMMY);
  localparam int FG_E   = frame_gap_eff(FRAME_GAP, ND_E);
  localparam int CNT_W  = $clog2(max_of(max_of(PAIRS, LG_E), FG_E) + 1);
  localparam int LINE_W = $clog2(LINES + 1);

  logic             fval_c, lval_c, dval_c, done_c;
  logic [CNT_W-1:0] pair;
  logic [PIX_W-1:0] col_even, col_odd;

  vtg_seq #(
    .PAIRS(PAIRS), .LINES(LINES), .LG(LG_E), .FG(FG_E), .ND(ND_E),
    .CNT_W(CNT_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .en(en),
    .fval_c(fval_c), .lval_c(lval_c), .dval_c(dval_c), .done_c(done_c),
    .pair(pair)
  );

  vtg_pattern #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_pat (
    .pair(pair), .col_even(col_even), .col_odd(col_odd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fval       <= 1'b0;
      lval       <= 1'b0;
      dval       <= 1'b0;
      frame_done <= 1'b0;
      tap_a      <= '0;
      tap_b      <= '0;
    end else begin
      fval       <= fval_c;
      lval       <= lval_c;
      dval       <= dval_c;
      frame_done <= done_c;
      tap_a      <= col_even;
      tap_b      <= col_odd;
    end
  end

  // Named events on the registered outputs, for the assertions below.
  logic       fval_d, lval_d, dval_d, seen_frame;
  logic [7:0] lval_low_run, fval_low_run;
  logic       lval_rise, fval_rise, fval_fall, dval_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      fval_d       <= 1'b0;
      lval_d       <= 1'b0;
      dval_d       <= 1'b0;
      seen_frame   <= 1'b0;
      lval_low_run <= 8'hFF;
      fval_low_run <= 8'hFF;
    end else begin
      fval_d       <= fval;
      lval_d       <= lval;
      dval_d       <= dval;
      seen_frame   <= seen_frame | fval;
      lval_low_run <= lval ? 8'd0 : ((lval_low_run == 8'hFF) ? 8'hFF : lval_low_run + 8'd1);
      fval_low_run <= fval ? 8'd0 : ((fval_low_run == 8'hFF) ? 8'hFF : fval_low_run + 8'd1);
    end
  end

  assign lval_rise = lval & ~lval_d;
  assign fval_rise = fval & ~fval_d;
  assign fval_fall = ~fval & fval_d;
  assign dval_rise = dval & ~dval_d;

  a_r3_dval_framed: assert property (@(posedge clk) disable iff (rst)
    dval |-> (lval && fval));

  a_r2_first_pair: assert property (@(posedge clk) disable iff (rst)
    dval_rise |-> (tap_a == '0 && tap_b == PIX_W'(1)));

  a_r5_lval_blank: assert property (@(posedge clk) disable iff (rst)
    lval_rise |-> (lval_low_run >= 8'(MIN_LINE_GAP)));

  a_r6_fval_blank: assert property (@(posedge clk) disable iff (rst)
    (fval_rise && seen_frame) |-> (fval_low_run >= 8'(MIN_FRAME_GAP)));

  a_r8_fval_leads: assert property (@(posedge clk) disable iff (rst)
    (lval_rise && fval) |-> fval_d);

  a_r8_fval_trails: assert property (@(posedge clk) disable iff (rst)
    fval_fall |-> !lval_d);

  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> fval_fall);

endmodule

// File: tb/vid_timing_gen_tb.sv
module vtg_mon #(
  parameter int PIX_W     = 10,
  parameter int PIXELS    = 640,
  parameter int LINES     = 480,
  parameter int LINE_GAP  = 4,
  parameter int FRAME_GAP = 100,
  parameter int DUMMY     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fval,
  input  logic             lval,
  input  logic             dval,
  input  logic [PIX_W-1:0] tap_a,
  input  logic [PIX_W-1:0] tap_b,
  input  logic             done,
  output int               checks,
  output int               fails,
  output int               frames
);
  function automatic int biggest(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  localparam int EXP_PAIRS = PIXELS / 2;
  localparam int EXP_LG    = (LINE_GAP < 4) ? 4 : LINE_GAP;
  localparam int EXP_ND    = (DUMMY < 4) ? 4 : DUMMY;
  localparam int EXP_FG    = biggest(FRAME_GAP, 100, EXP_ND * 8 + 4);
  localparam int WRAP      = 1 << PIX_W;

  int pl, pf, pd;
  int lo_run, hi_run, f_lo_run, f_hi_run, lines, dummies, col;
  bit seen;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial begin
    checks = 0; fails = 0; frames = 0;
    pl = 0; pf = 0; pd = 0; lo_run = 0; hi_run = 0; f_lo_run = 0; f_hi_run = 0;
    lines = 0; dummies = 0; col = 0; seen = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit lr, lf, fr, ff;
      lr = lval && !pl; lf = !lval && pl; fr = fval && !pf; ff = !fval && pf;
      // R3
      if (dval) chk(lval && fval, "R3 dval outside lval/fval", {lval, fval}, 3);
      if (fval) chk(lval == dval, "R3 dval vs lval in frame", dval, lval);
      if (dval) begin
        if (!pd) begin
          col = 0;
          chk(tap_a == 0 && tap_b == 1, "R2 line start pair", {tap_a, tap_b}, 1);
        end
        chk(int'(tap_a) == (2 * col) % WRAP, "R1 tap_a column", tap_a, (2 * col) % WRAP);
        chk(int'(tap_b) == (2 * col + 1) % WRAP, "R1 tap_b column", tap_b, (2 * col + 1) % WRAP);
        col++;
      end
      if (lf && fval) begin
        chk(hi_run == EXP_PAIRS, "R4 line length", hi_run, EXP_PAIRS);
        lines++;
      end
      if (lr && fval) begin
        if (lines == 0) chk(f_hi_run == 1, "R8 fval lead", f_hi_run, 1);
        else chk(lo_run == EXP_LG, "R5 line gap", lo_run, EXP_LG);
      end
      if (ff) begin
        chk(lines == LINES, "R4 lines per frame", lines, LINES);
        chk(lo_run == 1, "R8 fval trail", lo_run, 1);
        chk(done, "R10 done at fval fall", done, 1);
        frames++; lines = 0; dummies = 0;
      end else if (done) begin
        chk(0, "R10 stray done", 1, 0);
      end
      if (!fval && lr) begin
        dummies++;
        chk(lo_run >= 4, "R7 dummy low spacing", lo_run, 4);
      end
      if (!fval && lf) chk(hi_run == 4, "R7 dummy width", hi_run, 4);
      if (fr) begin
        if (seen) begin
          chk(f_lo_run >= EXP_FG, "R6 frame gap", f_lo_run, EXP_FG);
          chk(dummies == EXP_ND, "R7 dummy count", dummies, EXP_ND);
        end
        seen = 1; dummies = 0;
      end
      if (lval) begin hi_run = lr ? 1 : hi_run + 1; lo_run = 0; end
      else begin lo_run = lf ? 1 : lo_run + 1; hi_run = 0; end
      if (fval) begin f_hi_run = fr ? 1 : f_hi_run + 1; f_lo_run = 0; end
      else begin f_lo_run = ff ? 1 : f_lo_run + 1; f_hi_run = 0; end
      pl = lval; pf = fval; pd = dval;
    end
  end
endmodule

module vid_timing_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #4 clk = ~clk;

  logic fv1, lv1, dv1, dn1, fv2, lv2, dv2, dn2;
  logic [9:0] ta1, tb1;
  logic [3:0] ta2, tb2;
  int mc1, mf1, fr1, mc2, mf2, fr2;
  int tb_checks = 0, tb_fails = 0, cyc = 0;

  vid_timing_gen #(.PIX_W(10), .PIXELS_PER_LINE(1030), .LINES_PER_FRAME(3),
    .LINE_GAP(2), .FRAME_GAP(50), .DUMMY_LINES(2)) u_dut (
    .clk(clk), .rst(rst), .en(en), .fval(fv1), .lval(lv1), .dval(dv1),
    .tap_a(ta1), .tap_b(tb1), .frame_done(dn1));

  vid_timing_gen #(.PIX_W(4), .PIXELS_PER_LINE(20), .LINES_PER_FRAME(2),
    .LINE_GAP(7), .FRAME_GAP(120), .DUMMY_LINES(15)) u_dut_b (
    .clk(clk), .rst(rst), .en(en), .fval(fv2), .lval(lv2), .dval(dv2),
    .tap_a(ta2), .tap_b(tb2), .frame_done(dn2));

  vtg_mon #(.PIX_W(10), .PIXELS(1030), .LINES(3), .LINE_GAP(2), .FRAME_GAP(50),
    .DUMMY(2)) u_mon1 (.clk(clk), .rst(rst), .fval(fv1), .lval(lv1), .dval(dv1),
    .tap_a(ta1), .tap_b(tb1), .done(dn1), .checks(mc1), .fails(mf1), .frames(fr1));

  vtg_mon #(.PIX_W(4), .PIXELS(20), .LINES(2), .LINE_GAP(7), .FRAME_GAP(120),
    .DUMMY(15)) u_mon2 (.clk(clk), .rst(rst), .fval(fv2), .lval(lv2), .dval(dv2),
    .tap_a(ta2), .tap_b(tb2), .done(dn2), .checks(mc2), .fails(mf2), .frames(fr2));

  task automatic chk(bit ok, string req, int act, int exp);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    int total, failed;
    total  = tb_checks + mc1 + mc2;
    failed = tb_fails + mf1 + mf2;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic idle_check(int n, string req);
    repeat (n) begin
      @(negedge clk);
      chk({fv1, lv1, dv1, dn1, fv2, lv2, dv2, dn2} == 8'd0, req,
          {fv1, lv1, dv1, dn1, fv2, lv2, dv2, dn2}, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tb_checks++; tb_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    int r, f1, f2;
    r = $urandom(32'd7319);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk({fv1, lv1, dv1, dn1, fv2, lv2, dv2, dn2} == 8'd0, "R9 reset state", fv1, 0);
    rst = 1'b0;
    idle_check(40, "R9 idle with en low");
    // Directed: a single-clock enable gives exactly one frame per instance (R9).
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    repeat (1800) @(negedge clk);
    chk(fr1 == 1, "R9 one frame from pulse (a)", fr1, 1);
    chk(fr2 == 1, "R9 one frame from pulse (b)", fr2, 1);
    idle_check(60, "R9 idle after pulse");
    // Random enable windows, dropped at arbitrary frame positions.
    for (int k = 0; k < 4; k++) begin
      int len;
      len = 2000 + int'($urandom % 4000);
      f1 = fr1; f2 = fr2;
      en = 1'b1;
      repeat (len) @(negedge clk);
      en = 1'b0;
      repeat (1800) @(negedge clk);
      chk(fr1 > f1, "R9 frames completed (a)", fr1 - f1, 1);
      chk(fr2 > f2, "R9 frames completed (b)", fr2 - f2, 1);
      idle_check(60, "R9 idle after en drop");
    end
    summary();
  end
endmodule